// File: doc/BRIEF.md
# Reservation Station with Wakeup and Oldest-First Select

This block is the instruction buffer that sits in front of a single functional unit in an out-of-order core. Each cycle it can take in one dispatched operation that carries two source operands. Each operand arrives either as a value or as the tag of a producer that has not finished yet. Entries that are waiting compare their pending tags against every result broadcast bus in every cycle. On a match they capture the broadcast value. Once both operands are present the entry can be issued. In each cycle the oldest entry that can issue is sent to the unit, and an entry whose last operand appears on a bus in the current cycle can be picked in that same cycle.

Normal operations release their entry when they issue. An operation marked as possibly excepting behaves differently. It keeps its entry after issue and becomes a candidate again only when a replay request names its slot. The entry is freed only when a clean-finish report names the slot. Dispatch is refused while every entry is occupied. A flush empties the whole station.

Top module: `rs_wakeup_select`

## Requirements
- R1: After reset, `disp_ready` is 1 and `iss_valid` is 0.
- R2: An accepted dispatch goes into the lowest-numbered free entry, and that index is reported as `iss_slot` when the entry issues.
- R3: An operand whose valid flag is 1 is kept as the given value. An operand whose valid flag is 0 waits until its tag appears on any broadcast bus whose valid bit is set, and then takes that bus's data. Broadcasts with other tags have no effect.
- R4: An entry becomes eligible once both operands are present, and `iss_valid` rises one clock edge later. If both operands are present at dispatch, it issues two edges after the dispatch edge. If the last operand is broadcast in cycle t, the issue is visible after the edge that ends cycle t and carries the broadcast value.
- R5: At most one entry issues per cycle. When several are eligible, the one dispatched earliest issues first, whatever its entry index.
- R6: A dispatched operand that is pending, and whose tag is on a broadcast bus in the dispatch cycle, captures that data at dispatch.
- R7: A normal entry is freed by its issue. When all entries are occupied, `disp_ready` is 0 and a dispatch presented then is ignored.
- R8: An entry dispatched with `disp_may_except`=1 stays occupied after issue and does not issue again by itself. `replay_valid` with its slot makes it issue again with the same operands. `fin_valid` with its slot frees it.
- R9: `flush` frees every entry and cancels any issue pending in the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all entries |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | A free entry exists |
| disp_op | input | OP_W | Operation code |
| disp_dst | input | TAG_W | Destination tag |
| disp_may_except | input | 1 | Hold the entry until clean finish |
| disp_a_valid | input | 1 | Operand A is a value (1) or a tag (0) |
| disp_a_tag | input | TAG_W | Operand A producer tag |
| disp_a_data | input | DATA_W | Operand A value |
| disp_b_valid | input | 1 | Operand B is a value (1) or a tag (0) |
| disp_b_tag | input | TAG_W | Operand B producer tag |
| disp_b_data | input | DATA_W | Operand B value |
| bc_valid | input | NBUS | Per-bus broadcast valid |
| bc_tag | input | NBUS*TAG_W | Broadcast tags, bus k at bits k*TAG_W |
| bc_data | input | NBUS*DATA_W | Broadcast data, bus k at bits k*DATA_W |
| fin_valid | input | 1 | Clean finish of a held entry |
| fin_slot | input | IDX_W | Slot that finished |
| replay_valid | input | 1 | Reissue request for a held entry |
| replay_slot | input | IDX_W | Slot to reissue |
| iss_valid | output | 1 | Registered issue to the unit |
| iss_slot | output | IDX_W | Entry index issued |
| iss_op | output | OP_W | Operation issued |
| iss_dst | output | TAG_W | Destination tag issued |
| iss_a | output | DATA_W | Operand A issued |
| iss_b | output | DATA_W | Operand B issued |

## Verification
A busy state that is lost or stuck shows up at once at the ports. Either `disp_ready` drops before all slots are used, or a later dispatch lands in an unexpected `iss_slot` two edges after the dispatch. A tag compare that misses a broadcast leaves `iss_valid` low in the cycle after the broadcast, and a compare that captures from the wrong bus shows as a wrong `iss_a` or `iss_b` in that same cycle. A corrupted age order shows as two simultaneously woken entries leaving in swapped `iss_slot` order on consecutive cycles.

// File: rtl/rs_pkg.sv
package rs_pkg;
  // Life cycle of one station slot.
  typedef enum logic [1:0] {
    RS_FREE = 2'd0,  // unallocated
    RS_LIVE = 2'd1,  // allocated, may issue when operands present
    RS_HELD = 2'd2   // issued but kept for possible replay
  } slot_st_e;
endpackage

// File: rtl/rs_alloc.sv
module rs_alloc #(
  parameter int ENTRIES = 8
) (
  input  logic [ENTRIES-1:0] busy,
  output logic [ENTRIES-1:0] pick_oh,
  output logic               any_free
);
  // Lowest-index free slot wins.
  always_comb begin
    logic found;
    found   = 1'b0;
    pick_oh = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!busy[i] && !found) begin
        pick_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
    any_free = found;
  end
endmodule

// File: rtl/rs_age_select.sv
module rs_age_select #(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] alloc_oh,
  input  logic [ENTRIES-1:0] elig,
  output logic [ENTRIES-1:0] grant
);
  // older[i][j] == 1 : slot i was allocated before slot j
  logic [ENTRIES-1:0] older [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) older[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        for (int j = 0; j < ENTRIES; j++) begin
          if (alloc_oh[j] && (i != j)) older[i][j] <= 1'b1;
          else if (alloc_oh[i])        older[i][j] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < ENTRIES; j++) begin
        if (elig[j] && older[j][i]) blocked = 1'b1;
      end
      grant[i] = elig[i] && !blocked;
    end
  end

  // R5: never more than one winner
  a_r5_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
endmodule

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  parameter int OP_W   = 4,
  parameter int NBUS   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic                   alloc,
  input  logic [OP_W-1:0]        d_op,
  input  logic [TAG_W-1:0]       d_dst,
  input  logic                   d_exc,
  input  logic                   d_av,
  input  logic [TAG_W-1:0]       d_atag,
  input  logic [DATA_W-1:0]      d_adata,
  input  logic                   d_bv,
  input  logic [TAG_W-1:0]       d_btag,
  input  logic [DATA_W-1:0]      d_bdata,
  input  logic [NBUS-1:0]        bc_v,
  input  logic [NBUS*TAG_W-1:0]  bc_tag,
  input  logic [NBUS*DATA_W-1:0] bc_data,
  input  logic                   grant,
  input  logic                   fin,
  input  logic                   replay,
  output logic                   busy,
  output logic                   elig,
  output logic [OP_W-1:0]        o_op,
  output logic [TAG_W-1:0]       o_dst,
  output logic [DATA_W-1:0]      o_a,
  output logic [DATA_W-1:0]      o_b
);
  slot_st_e          st;
  logic [OP_W-1:0]   op_q;
  logic [TAG_W-1:0]  dst_q;
  logic              exc_q;
  logic              av_q, bv_q;
  logic [TAG_W-1:0]  atag_q, btag_q;
  logic [DATA_W-1:0] adata_q, bdata_q;

  // Search all buses for a tag; lowest bus index wins on a tie.
  function automatic logic [DATA_W:0] snoop(input logic [TAG_W-1:0] t);
    logic [DATA_W:0] r;
    r = '0;
    for (int k = NBUS-1; k >= 0; k--) begin
      if (bc_v[k] && (bc_tag[k*TAG_W +: TAG_W] == t))
        r = {1'b1, bc_data[k*DATA_W +: DATA_W]};
    end
    return r;
  endfunction

  logic [DATA_W:0] a_hit, b_hit, da_hit, db_hit;
  logic            a_ok, b_ok;

  always_comb begin
    a_hit  = snoop(atag_q);
    b_hit  = snoop(btag_q);
    da_hit = snoop(d_atag);
    db_hit = snoop(d_btag);
    a_ok   = av_q || a_hit[DATA_W];
    b_ok   = bv_q || b_hit[DATA_W];
    o_a    = av_q ? adata_q : a_hit[DATA_W-1:0];
    o_b    = bv_q ? bdata_q : b_hit[DATA_W-1:0];
    busy   = (st != RS_FREE);
    elig   = (st == RS_LIVE) && a_ok && b_ok;
    o_op   = op_q;
    o_dst  = dst_q;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      st   <= RS_FREE;
      av_q <= 1'b0;
      bv_q <= 1'b0;
    end else if (alloc) begin
      st      <= RS_LIVE;
      op_q    <= d_op;
      dst_q   <= d_dst;
      exc_q   <= d_exc;
      atag_q  <= d_atag;
      btag_q  <= d_btag;
      av_q    <= d_av || da_hit[DATA_W];
      bv_q    <= d_bv || db_hit[DATA_W];
      adata_q <= d_av ? d_adata : da_hit[DATA_W-1:0];
      bdata_q <= d_bv ? d_bdata : db_hit[DATA_W-1:0];
    end else begin
      if (st == RS_LIVE) begin
        if (!av_q && a_hit[DATA_W]) begin
          av_q    <= 1'b1;
          adata_q <= a_hit[DATA_W-1:0];
        end
        if (!bv_q && b_hit[DATA_W]) begin
          bv_q    <= 1'b1;
          bdata_q <= b_hit[DATA_W-1:0];
        end
        if (grant) st <= exc_q ? RS_HELD : RS_FREE;
      end else if (st == RS_HELD) begin
        if (fin)         st <= RS_FREE;
        else if (replay) st <= RS_LIVE;
      end
    end
  end

  // R4: a grant from the selector only reaches a slot holding both operands
  a_r4_grant_has_operands: assert property (@(posedge clk) disable iff (rst)
    grant |-> (a_ok && b_ok));
  // R8: a held slot is never granted
  a_r8_held_no_grant: assert property (@(posedge clk) disable iff (rst)
    (st == RS_HELD) |-> !grant);
endmodule

// File: rtl/rs_wakeup_select.sv
module rs_wakeup_select #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 6,
  parameter int DATA_W  = 16,
  parameter int OP_W    = 4,
  parameter int NBUS    = 2,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic                   disp_valid,
  output logic                   disp_ready,
  input  logic [OP_W-1:0]        disp_op,
  input  logic [TAG_W-1:0]       disp_dst,
  input  logic                   disp_may_except,
  input  logic                   disp_a_valid,
  input  logic [TAG_W-1:0]       disp_a_tag,
  input  logic [DATA_W-1:0]      disp_a_data,
  input  logic                   disp_b_valid,
  input  logic [TAG_W-1:0]       disp_b_tag,
  input  logic [DATA_W-1:0]      disp_b_data,
  input  logic [NBUS-1:0]        bc_valid,
  input  logic [NBUS*TAG_W-1:0]  bc_tag,
  input  logic [NBUS*DATA_W-1:0] bc_data,
  input  logic                   fin_valid,
  input  logic [IDX_W-1:0]       fin_slot,
  input  logic                   replay_valid,
  input  logic [IDX_W-1:0]       replay_slot,
  output logic                   iss_valid,
  output logic [IDX_W-1:0]       iss_slot,
  output logic [OP_W-1:0]        iss_op,
  output logic [TAG_W-1:0]       iss_dst,
  output logic [DATA_W-1:0]      iss_a,
  output logic [DATA_W-1:0]      iss_b
);
  logic [ENTRIES-1:0] busy, elig, grant, alloc_oh;
  logic               any_free, accept;
  logic [OP_W-1:0]    e_op  [ENTRIES];
  logic [TAG_W-1:0]   e_dst [ENTRIES];
  logic [DATA_W-1:0]  e_a   [ENTRIES];
  logic [DATA_W-1:0]  e_b   [ENTRIES];

  assign disp_ready = any_free;
  assign accept     = disp_valid && any_free;

  rs_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .busy     (busy),
    .pick_oh  (alloc_oh),
    .any_free (any_free)
  );

  rs_age_select #(.ENTRIES(ENTRIES)) u_age (
    .clk      (clk),
    .rst      (rst),
    .alloc_oh (alloc_oh & {ENTRIES{accept}}),
    .elig     (elig),
    .grant    (grant)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    rs_entry #(
      .TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W), .NBUS(NBUS)
    ) u_entry (
      .clk     (clk),
      .rst     (rst),
      .flush   (flush),
      .alloc   (accept && alloc_oh[i]),
      .d_op    (disp_op),
      .d_dst   (disp_dst),
      .d_exc   (disp_may_except),
      .d_av    (disp_a_valid),
      .d_atag  (disp_a_tag),
      .d_adata (disp_a_data),
      .d_bv    (disp_b_valid),
      .d_btag  (disp_b_tag),
      .d_bdata (disp_b_data),
      .bc_v    (bc_valid),
      .bc_tag  (bc_tag),
      .bc_data (bc_data),
      .grant   (grant[i]),
      .fin     (fin_valid && (fin_slot == IDX_W'(i))),
      .replay  (replay_valid && (replay_slot == IDX_W'(i))),
      .busy    (busy[i]),
      .elig    (elig[i]),
      .o_op    (e_op[i]),
      .o_dst   (e_dst[i]),
      .o_a     (e_a[i]),
      .o_b     (e_b[i])
    );
  end

  // One-hot mux of the granted slot.
  logic [IDX_W-1:0]  m_slot;
  logic [OP_W-1:0]   m_op;
  logic [TAG_W-1:0]  m_dst;
  logic [DATA_W-1:0] m_a, m_b;

  always_comb begin
    m_slot = '0;
    m_op   = '0;
    m_dst  = '0;
    m_a    = '0;
    m_b    = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (grant[i]) begin
        m_slot = IDX_W'(i);
        m_op   = e_op[i];
        m_dst  = e_dst[i];
        m_a    = e_a[i];
        m_b    = e_b[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      iss_valid <= 1'b0;
    end else begin
      iss_valid <= |grant;
    end
    if (|grant) begin
      iss_slot <= m_slot;
      iss_op   <= m_op;
      iss_dst  <= m_dst;
      iss_a    <= m_a;
      iss_b    <= m_b;
    end
  end

  // R2: allocator only ever points at a slot the entries report free
  a_r2_alloc_is_free: assert property (@(posedge clk) disable iff (rst)
    accept |-> ((alloc_oh & busy) == '0));
  // R7: with every slot occupied no dispatch is accepted
  a_r7_full_blocks: assert property (@(posedge clk) disable iff (rst)
    (busy == '1) |-> !disp_ready);
  // R9: a flush leaves nothing behind
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> ((busy == '0) && !iss_valid));
  // R4: an issue always follows a grant on the previous edge
  a_r4_issue_after_grant: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> $past(|grant));
endmodule

// File: tb/rs_wakeup_select_tb_top.sv
module rs_wakeup_select_tb_top;
  localparam int ENTRIES = 8;
  localparam int TAG_W   = 6;
  localparam int DATA_W  = 16;
  localparam int OP_W    = 4;
  localparam int NBUS    = 2;
  localparam int IDX_W   = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                   rst, flush, disp_valid, disp_ready, disp_may_except;
  logic [OP_W-1:0]        disp_op;
  logic [TAG_W-1:0]       disp_dst, disp_a_tag, disp_b_tag;
  logic                   disp_a_valid, disp_b_valid;
  logic [DATA_W-1:0]      disp_a_data, disp_b_data;
  logic [NBUS-1:0]        bc_valid;
  logic [NBUS*TAG_W-1:0]  bc_tag;
  logic [NBUS*DATA_W-1:0] bc_data;
  logic                   fin_valid, replay_valid;
  logic [IDX_W-1:0]       fin_slot, replay_slot;
  logic                   iss_valid;
  logic [IDX_W-1:0]       iss_slot;
  logic [OP_W-1:0]        iss_op;
  logic [TAG_W-1:0]       iss_dst;
  logic [DATA_W-1:0]      iss_a, iss_b;

  rs_wakeup_select #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W), .NBUS(NBUS)
  ) dut_i (.*);

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  localparam logic [15:0] VA [6] = '{16'h0001, 16'hFFFF, 16'h1234, 16'h8000, 16'h00A5, 16'h7E7E};
  localparam logic [15:0] VB [6] = '{16'h0002, 16'h0000, 16'h4321, 16'h0001, 16'h5A00, 16'hE7E7};
  localparam logic [5:0]  VD [6] = '{6'd1, 6'd63, 6'd17, 6'd32, 6'd5, 6'd40};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    disp_valid = 0; disp_may_except = 0; bc_valid = '0;
    fin_valid = 0; replay_valid = 0; flush = 0;
  endtask

  task automatic disp(input logic av, input logic [5:0] at, input logic [15:0] ad,
                      input logic bv, input logic [5:0] bt, input logic [15:0] bd,
                      input logic exc, input logic [5:0] dst);
    disp_valid = 1; disp_a_valid = av; disp_a_tag = at; disp_a_data = ad;
    disp_b_valid = bv; disp_b_tag = bt; disp_b_data = bd;
    disp_may_except = exc; disp_dst = dst; disp_op = dst[3:0];
  endtask

  task automatic bus(input int k, input logic [5:0] t, input logic [15:0] d);
    bc_valid[k] = 1'b1;
    bc_tag[k*TAG_W +: TAG_W] = t;
    bc_data[k*DATA_W +: DATA_W] = d;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1; idle();
    disp_op = '0; disp_dst = '0; disp_a_valid = 0; disp_a_tag = '0; disp_a_data = '0;
    disp_b_valid = 0; disp_b_tag = '0; disp_b_data = '0;
    bc_tag = '0; bc_data = '0; fin_slot = '0; replay_slot = '0;
    repeat (3) step();
    rst = 0;
    step();
    chk("R1 disp_ready", 32'(disp_ready), 1);
    chk("R1 iss_valid", 32'(iss_valid), 0);

    // Vector table: both operands as values, one op at a time
    for (int i = 0; i < 6; i++) begin
      disp(1, 0, VA[i], 1, 0, VB[i], 0, VD[i]);
      step(); idle();
      chk("R4 not before second edge", 32'(iss_valid), 0);
      step();
      chk("R4 iss_valid", 32'(iss_valid), 1);
      chk("R2 slot reuse", 32'(iss_slot), 0);
      chk("R3 value a", 32'(iss_a), 32'(VA[i]));
      chk("R3 value b", 32'(iss_b), 32'(VB[i]));
      chk("R2 dst", 32'(iss_dst), 32'(VD[i]));
    end

    // Pending operand woken by bus 1; unrelated tag on bus 0
    disp(1, 0, 16'h0011, 0, 6'd5, 16'h0, 0, 6'd2);
    step(); idle(); step(); step();
    chk("R3 waits for tag", 32'(iss_valid), 0);
    bus(0, 6'd9, 16'h1234); bus(1, 6'd5, 16'hBEEF);
    step(); idle();
    chk("R4 same-cycle issue", 32'(iss_valid), 1);
    chk("R3 captured b", 32'(iss_b), 32'hBEEF);
    chk("R3 kept a", 32'(iss_a), 32'h0011);
    step();
    chk("R5 single issue", 32'(iss_valid), 0);

    // Dispatch-cycle capture
    disp(0, 6'd12, 16'h0, 1, 0, 16'h0077, 0, 6'd3);
    bus(0, 6'd12, 16'hC0DE);
    step(); idle(); step();
    chk("R6 issue", 32'(iss_valid), 1);
    chk("R6 captured a", 32'(iss_a), 32'hC0DE);
    step();

    // Age order independent of slot index
    disp(0, 6'd30, 16'h0, 1, 0, 16'h1, 0, 6'd4); step();
    disp(0, 6'd31, 16'h0, 1, 0, 16'h2, 0, 6'd5); step(); idle();
    bus(0, 6'd30, 16'h3030); step(); idle();
    chk("R5 first slot", 32'(iss_slot), 0);
    disp(0, 6'd32, 16'h0, 1, 0, 16'h3, 0, 6'd6); step(); idle();
    bus(0, 6'd31, 16'h3131); bus(1, 6'd32, 16'h3232);
    step(); idle();
    chk("R5 oldest slot", 32'(iss_slot), 1);
    chk("R5 oldest data", 32'(iss_a), 32'h3131);
    step();
    chk("R5 younger next", 32'(iss_valid), 1);
    chk("R5 younger slot", 32'(iss_slot), 0);
    chk("R5 younger data", 32'(iss_a), 32'h3232);
    step();

    // Fill the station
    for (int k = 0; k < ENTRIES; k++) begin
      disp(0, 6'd40, 16'h0, 1, 0, 16'h9, 0, 6'(k));
      step();
    end
    idle();
    chk("R7 full", 32'(disp_ready), 0);
    disp(1, 0, 16'h5555, 1, 0, 16'h5555, 0, 6'd7);
    step(); idle(); step();
    chk("R7 ignored dispatch", 32'(iss_valid), 0);
    step();
    chk("R7 ignored dispatch later", 32'(iss_valid), 0);

    // Flush
    flush = 1; step(); flush = 0;
    chk("R9 ready after flush", 32'(disp_ready), 1);
    chk("R9 no issue", 32'(iss_valid), 0);
    bus(0, 6'd40, 16'hAAAA); step(); idle();
    chk("R9 flushed entries silent", 32'(iss_valid), 0);
    step();
    chk("R9 still silent", 32'(iss_valid), 0);

    // Excepting operation retention, replay and finish
    disp(1, 0, 16'h00E1, 1, 0, 16'h00E2, 1, 6'd8);
    step(); idle(); step();
    chk("R8 first issue", 32'(iss_valid), 1);
    chk("R8 first slot", 32'(iss_slot), 0);
    step(); step();
    chk("R8 no self reissue", 32'(iss_valid), 0);
    disp(1, 0, 16'h000A, 1, 0, 16'h000B, 0, 6'd9);
    step(); idle(); step();
    chk("R8 slot retained", 32'(iss_slot), 1);
    replay_valid = 1; replay_slot = 3'd0;
    step(); idle(); step();
    chk("R8 replay issue", 32'(iss_valid), 1);
    chk("R8 replay slot", 32'(iss_slot), 0);
    chk("R8 replay data", 32'(iss_a), 32'h00E1);
    fin_valid = 1; fin_slot = 3'd0;
    step(); idle();
    disp(1, 0, 16'h000F, 1, 0, 16'h0010, 0, 6'd10);
    step(); idle(); step();
    chk("R8 freed by finish", 32'(iss_slot), 0);
    chk("R8 new data", 32'(iss_a), 32'h000F);

    done = 1;
    summary();
    $finish;
  end
endmodule